// File: doc/BRIEF.md
# Decimal-to-BCD Priority Encoder

This block takes nine request lines, one for each of the decimal digits 1 through 9, and returns the digit as a 4-bit BCD code. Digit zero has no line of its own. The block reports zero when no line is asserted. When several lines are asserted together, the block encodes only the largest digit among them. A typical use is a simple decimal keypad, or any group of nine sources where the highest-numbered active source must be named.

Requests are active-low. The output is active-low by default, and a parameter makes it active-high. A second parameter places a clocked register on the output for synchronous use. That register has a synchronous active-high reset, which loads the code for zero. When the register is left out, the encoder is purely combinational from requests to output. In that case the clock and reset have no effect.

Top module: `dec_prio_enc`

## Requirements
- R1: Input `req_n` is active-low: bit k-1 at 0 asserts digit k, for k from 1 to 9, and there is no line for digit 0.
- R2: When all nine bits of `req_n` are 1 (no request), the encoded value is 0.
- R3: When several requests are asserted, the encoded value is the largest asserted digit (for example, digits 6 and 7 together give 7).
- R4: The encoded value never exceeds 9 (binary 1001) for any of the 512 request patterns.
- R5: With `OUT_ACT_HIGH`=0, `bcd` is the bitwise inverse of the encoded value (zero reads 4'b1111). With `OUT_ACT_HIGH`=1, `bcd` equals the encoded value.
- R6: With `REG_OUT`=1, `bcd` shows the value for the request pattern sampled at the previous rising clock edge. With `REG_OUT`=0, `bcd` follows `req_n` with no clock delay.
- R7: With `REG_OUT`=1, a rising edge with `rst` at 1 loads `bcd` with the code for zero, whatever requests are present.
- R8: A single asserted request for digit k gives encoded value k, for each k from 1 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| req_n | input | 9 | Active-low digit requests; bit k-1 is digit k |
| bcd | output | 4 | BCD code of the winning digit, in the selected polarity |

## Verification
A wrong priority choice shows at the output as a smaller digit whenever a higher request coexists with a lower one. In the registered build, this shows one clock after the pattern is applied; in the combinational build, it shows at once. A range fault shows as a code between 1010 and 1111 in logical terms. A stuck or skipped output register shows as a value that lags by the wrong number of cycles, or as a reset that does not return the zero code on the next edge. Every one of the 512 patterns is applied to both the registered active-low build and the combinational active-high build. Each result is compared against a top-down reference scan.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
    localparam int unsigned NUM_DIGITS = 9;
    localparam int unsigned CODE_W     = $clog2(NUM_DIGITS + 1);

    typedef logic [NUM_DIGITS-1:0] req_vec_t;
    typedef logic [CODE_W-1:0]     code_t;
endpackage

// File: rtl/dpe_req_norm.sv
module dpe_req_norm
    import dpe_pkg::*;
(
    input  req_vec_t req_n,
    output req_vec_t act
);
    // Active-low lines become active-high request flags.
    assign act = ~req_n;
endmodule

// File: rtl/dpe_prio_pick.sv
module dpe_prio_pick
    import dpe_pkg::*;
(
    input  req_vec_t act,
    output code_t    val
);
    // Ascending scan: a later (higher) digit overrides any lower one.
    always_comb begin
        val = '0;
        for (int k = 1; k <= NUM_DIGITS; k++) begin
            if (act[k-1]) val = code_t'(k);
        end
    end
endmodule

// File: rtl/dpe_out_stage.sv
module dpe_out_stage
    import dpe_pkg::*;
#(
    parameter bit REG_OUT      = 1'b1,
    parameter bit OUT_ACT_HIGH = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  code_t val,
    output code_t q
);
    localparam code_t ZERO_CODE = OUT_ACT_HIGH ? code_t'(0) : ~code_t'(0);

    code_t coded;
    assign coded = OUT_ACT_HIGH ? val : ~val;

    generate
        if (REG_OUT) begin : g_reg
            code_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= ZERO_CODE;
                else     q_r <= coded;
            end
            assign q = q_r;

            // R6
            reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
                !rst |=> q == $past(coded));
            // R7
            reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> q == ZERO_CODE);
        end else begin : g_comb
            assign q = coded;
        end
    endgenerate
endmodule

// File: rtl/dec_prio_enc.sv
module dec_prio_enc
    import dpe_pkg::*;
#(
    parameter bit REG_OUT      = 1'b1,
    parameter bit OUT_ACT_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [8:0] req_n,
    output logic [3:0] bcd
);
    req_vec_t act;
    code_t    val;

    dpe_req_norm u_norm (
        .req_n (req_n),
        .act   (act)
    );

    dpe_prio_pick u_pick (
        .act (act),
        .val (val)
    );

    dpe_out_stage #(
        .REG_OUT      (REG_OUT),
        .OUT_ACT_HIGH (OUT_ACT_HIGH)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .val (val),
        .q   (bcd)
    );

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        val <= code_t'(9));
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (&req_n) |-> val == '0);
    // R3
    top_digit_chk: assert property (@(posedge clk) disable iff (rst)
        !req_n[8] |-> val == code_t'(9));
    // R1
    lone_one_chk: assert property (@(posedge clk) disable iff (rst)
        (req_n == 9'h1FE) |-> val == code_t'(1));
endmodule

// File: tb/sim_dec_prio_enc.sv
`timescale 1ns/1ps
module sim_dec_prio_enc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] req_n = 9'h1FF;
    logic [3:0] bcd_reg;
    logic [3:0] bcd_cmb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [3:0] exp_q[$];

    always #2 clk = ~clk;

    dec_prio_enc #(.REG_OUT(1'b1), .OUT_ACT_HIGH(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_n(req_n), .bcd(bcd_reg));

    dec_prio_enc #(.REG_OUT(1'b0), .OUT_ACT_HIGH(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_n(req_n), .bcd(bcd_cmb));

    // Top-down reference scan: first asserted line from digit 9 wins.
    function automatic logic [3:0] ref_val(input logic [8:0] r);
        for (int k = 9; k >= 1; k--) begin
            if (r[k-1] == 1'b0) return 4'(k);
        end
        return 4'd0;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply pattern, queue expected registered code, check comb build.
    task automatic drive(input logic [8:0] p);
        logic [3:0] v;
        @(negedge clk);
        req_n = p;
        v = ref_val(p);
        exp_q.push_back(~v);
        #1;
        check("R5/R6 comb", bcd_cmb, v);
        check("R4 range", {3'b000, (bcd_cmb > 4'd9)}, 4'd0);
    endtask

    // Monitor: registered build updates at the edge after the pattern.
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            logic [3:0] e;
            e = exp_q.pop_front();
            check("R3/R5/R6 reg", bcd_reg, e);
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset", bcd_reg, 4'hF);
        rst = 1'b0;
        // R2: idle pattern
        drive(9'h1FF);
        // R8 / R1: each single digit
        for (int k = 1; k <= 9; k++) drive(~(9'h001 << (k-1)));
        // R3: digits 6 and 7 together
        drive(~9'b001100000);
        // R3 R4: exhaustive 512 patterns
        for (int p = 0; p < 512; p++) drive(9'(p));
        repeat (2) @(negedge clk);
        check("R6 drained", {3'b000, exp_q.size() != 0}, 4'd0);
        // R7: reset with requests active
        req_n = 9'h000;
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset busy", bcd_reg, 4'hF);
        check("R6 comb ignores reset", bcd_cmb, 4'd9);
        rst = 1'b0;
        @(negedge clk);
        check("R6 after reset", bcd_reg, ~4'd9);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule